// File: doc/BRIEF.md
# Message Buffer Address Mapper

This block translates a logical message buffer number into the place where that buffer's header lives in a shared frame memory. Each logical buffer has its own programmable index register. The header start address is that index times ten plus a common base address. The mapper also reports three more things about the buffer:

- which of two buffer segments it belongs to,
- the minimum data field length that segment requires,
- which of four receive shadow buffers serves the requested channel in that segment.

A controller issues a lookup with a buffer number and a channel. The results come back one clock later with a valid strobe. All index registers and configuration fields are loaded through a simple write port. The port uses a kind code that selects the register, a buffer number that selects the index register, and a data word.

Top module: `mbuf_addr_map`

## Requirements
- R1: For an in-range buffer, `rsp_hdr_addr` equals (index register of that buffer × 10 + base address), truncated to ADDR_W bits.
- R2: `rsp_seg` is 0 (first segment) when the requested buffer number is less than or equal to the programmed last-of-first-segment value. Otherwise it is 1.
- R3: `rsp_min_len` equals 2 × the data size field of the segment reported in `rsp_seg`, in bytes.
- R4: `rsp_shadow` is the 2-bit code {rsp_seg, channel}. Channel A is `req_chan`=0 and channel B is `req_chan`=1, so the four codes 0..3 name the four shadow buffers.
- R5: Results and `rsp_valid`=1 appear on the clock edge after a cycle with `req_valid`=1. `rsp_valid` is 0 after a cycle without a request.
- R6: A configuration write takes effect for lookups that start on the following cycle. A lookup issued in the same cycle as the write sees the old value. Kind codes: 0 = index register, 1 = base address, 2 = last-of-first-segment, 3 = first-segment data size, 4 = second-segment data size. Codes 5 to 7 change nothing.
- R7: A write to one buffer's index register changes only that buffer's mapping. An index write naming a buffer number ≥ NUM_BUF changes nothing.
- R8: A request for a buffer number ≥ NUM_BUF returns `rsp_err`=1 and `rsp_hdr_addr`=0. An in-range request returns `rsp_err`=0.
- R9: After reset `rsp_valid` is 0, and every index register and configuration field reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Register selected by the write (see R6) |
| cfg_buf | input | NUM_W | Buffer number for an index register write |
| cfg_wdata | input | ADDR_W | Write data; low bits used per field |
| req_valid | input | 1 | Lookup request |
| req_buf | input | NUM_W | Logical buffer number to look up |
| req_chan | input | 1 | Channel, 0 = A, 1 = B |
| rsp_valid | output | 1 | Results valid |
| rsp_hdr_addr | output | ADDR_W | Header field start address |
| rsp_seg | output | 1 | Segment, 0 = first, 1 = second |
| rsp_min_len | output | SIZE_W+1 | Minimum data field length in bytes |
| rsp_shadow | output | 2 | Receive shadow buffer code {seg, chan} |
| rsp_err | output | 1 | Buffer number out of range |

## Verification
Every lookup result is due exactly one rising edge after the request cycle. The bench drives a request on a falling edge and drops it just after the next rising edge. It then reads all outputs on the following falling edge, so each sample lands in the cycle the output register has just loaded.

A configuration write takes one edge to land. The bench therefore updates its own model only after that edge. For the same-cycle case it places the write and the request in the same cycle and expects the old value back.

// File: rtl/mbam_pkg.sv
package mbam_pkg;

   typedef enum logic [2:0] {
      CFG_INDEX = 3'd0,
      CFG_BASE  = 3'd1,
      CFG_LAST1 = 3'd2,
      CFG_SIZE1 = 3'd3,
      CFG_SIZE2 = 3'd4
   } cfg_kind_e;

   localparam int MULT_SHIFT_ADD = 0;
   localparam int MULT_OPERATOR  = 1;

endpackage

// File: rtl/mbam_cfg_regs.sv
module mbam_cfg_regs
   import mbam_pkg::*;
#(
   parameter int NUM_BUF = 16,
   parameter int NUM_W   = 6,
   parameter int IDX_W   = 8,
   parameter int ADDR_W  = 16,
   parameter int SIZE_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_kind,
   input  logic [NUM_W-1:0]  cfg_buf,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [NUM_W-1:0]  rd_buf,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] base_q,
   output logic [NUM_W-1:0]  last_q,
   output logic [SIZE_W-1:0] size1_q,
   output logic [SIZE_W-1:0] size2_q
);

   logic [IDX_W-1:0] idx_q [NUM_BUF];

   logic index_sel;
   assign index_sel = cfg_we && (cfg_kind == CFG_INDEX);

   // one register per logical buffer, each with its own decoded enable
   for (genvar g = 0; g < NUM_BUF; g++) begin : g_idx
      logic hit;
      assign hit = index_sel && (cfg_buf == NUM_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   idx_q[g] <= '0;
         else if (hit) idx_q[g] <= cfg_wdata[IDX_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         last_q  <= '0;
         size1_q <= '0;
         size2_q <= '0;
      end else if (cfg_we) begin
         case (cfg_kind)
            CFG_BASE:  base_q  <= cfg_wdata;
            CFG_LAST1: last_q  <= cfg_wdata[NUM_W-1:0];
            CFG_SIZE1: size1_q <= cfg_wdata[SIZE_W-1:0];
            CFG_SIZE2: size2_q <= cfg_wdata[SIZE_W-1:0];
            default: ;
         endcase
      end
   end

   // read port: an out-of-range number reads zero
   always_comb begin
      rd_idx = '0;
      for (int i = 0; i < NUM_BUF; i++)
         if (rd_buf == NUM_W'(i)) rd_idx = idx_q[i];
   end

endmodule

// File: rtl/mbam_hdr_addr.sv
module mbam_hdr_addr
   import mbam_pkg::*;
#(
   parameter int IDX_W      = 8,
   parameter int ADDR_W     = 16,
   parameter int MULT_STYLE = MULT_SHIFT_ADD
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] hdr_addr
);

   localparam int PROD_W = IDX_W + 4;
   localparam int SUM_W  = (PROD_W > ADDR_W) ? PROD_W : ADDR_W;

   logic [PROD_W-1:0] times_ten;

   if (MULT_STYLE == MULT_SHIFT_ADD) begin : g_shift
      logic [PROD_W-1:0] ext;
      assign ext       = PROD_W'(idx);
      assign times_ten = (ext << 3) + (ext << 1);
   end else if (MULT_STYLE == MULT_OPERATOR) begin : g_mult
      assign times_ten = PROD_W'(idx) * PROD_W'(10);
   end else begin : g_bad_style
      $error("mbam_hdr_addr: unsupported MULT_STYLE");
      assign times_ten = '0;
   end

   logic [SUM_W-1:0] sum;
   assign sum      = SUM_W'(times_ten) + SUM_W'(base);
   assign hdr_addr = sum[ADDR_W-1:0];

endmodule

// File: rtl/mbam_seg_decode.sv
module mbam_seg_decode #(
   parameter int NUM_BUF = 16,
   parameter int NUM_W   = 6,
   parameter int SIZE_W  = 7
) (
   input  logic [NUM_W-1:0]  buf_num,
   input  logic              chan,
   input  logic [NUM_W-1:0]  last1,
   input  logic [SIZE_W-1:0] size1,
   input  logic [SIZE_W-1:0] size2,
   output logic              seg,
   output logic [SIZE_W:0]   min_len,
   output logic [1:0]        shadow,
   output logic              out_of_range
);

   localparam int CNT_W = NUM_W + 1;

   logic [SIZE_W-1:0] size_sel;

   assign seg          = (buf_num > last1);
   assign size_sel     = seg ? size2 : size1;
   assign min_len      = {size_sel, 1'b0};
   assign shadow       = {seg, chan};
   assign out_of_range = (CNT_W'(buf_num) >= CNT_W'(NUM_BUF));

endmodule

// File: rtl/mbuf_addr_map.sv
module mbuf_addr_map
   import mbam_pkg::*;
#(
   parameter int NUM_BUF    = 16,
   parameter int NUM_W      = 6,
   parameter int IDX_W      = 8,
   parameter int ADDR_W     = 16,
   parameter int SIZE_W     = 7,
   parameter int MULT_STYLE = MULT_SHIFT_ADD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_kind,
   input  logic [NUM_W-1:0]  cfg_buf,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              req_valid,
   input  logic [NUM_W-1:0]  req_buf,
   input  logic              req_chan,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_hdr_addr,
   output logic              rsp_seg,
   output logic [SIZE_W:0]   rsp_min_len,
   output logic [1:0]        rsp_shadow,
   output logic              rsp_err
);

   localparam int LEN_W = SIZE_W + 1;

   if (NUM_BUF < 1 || NUM_BUF > (1 << NUM_W)) begin : g_chk_count
      $error("mbuf_addr_map: NUM_BUF must fit in NUM_W bits");
   end
   if (ADDR_W < IDX_W || SIZE_W < 1) begin : g_chk_width
      $error("mbuf_addr_map: ADDR_W must cover IDX_W and SIZE_W must be positive");
   end

   logic [IDX_W-1:0]  rd_idx;
   logic [ADDR_W-1:0] base_q;
   logic [NUM_W-1:0]  last_q;
   logic [SIZE_W-1:0] size1_q, size2_q;
   logic [ADDR_W-1:0] hdr_addr;
   logic              seg, oor;
   logic [LEN_W-1:0]  min_len;
   logic [1:0]        shadow;

   mbam_cfg_regs #(
      .NUM_BUF(NUM_BUF), .NUM_W(NUM_W), .IDX_W(IDX_W),
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_buf(cfg_buf), .cfg_wdata(cfg_wdata),
      .rd_buf(req_buf), .rd_idx(rd_idx),
      .base_q(base_q), .last_q(last_q), .size1_q(size1_q), .size2_q(size2_q)
   );

   mbam_hdr_addr #(
      .IDX_W(IDX_W), .ADDR_W(ADDR_W), .MULT_STYLE(MULT_STYLE)
   ) u_addr (
      .idx(rd_idx), .base(base_q), .hdr_addr(hdr_addr)
   );

   mbam_seg_decode #(
      .NUM_BUF(NUM_BUF), .NUM_W(NUM_W), .SIZE_W(SIZE_W)
   ) u_seg (
      .buf_num(req_buf), .chan(req_chan), .last1(last_q),
      .size1(size1_q), .size2(size2_q),
      .seg(seg), .min_len(min_len), .shadow(shadow), .out_of_range(oor)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hdr_addr <= '0;
         rsp_seg      <= 1'b0;
         rsp_min_len  <= '0;
         rsp_shadow   <= '0;
         rsp_err      <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hdr_addr <= oor ? '0 : hdr_addr;
            rsp_seg      <= seg;
            rsp_min_len  <= min_len;
            rsp_shadow   <= shadow;
            rsp_err      <= oor;
         end
      end
   end

endmodule

// File: rtl/mbam_checker.sv
module mbam_checker #(
   parameter int NUM_BUF = 16,
   parameter int NUM_W   = 6,
   parameter int ADDR_W  = 16,
   parameter int SIZE_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [NUM_W-1:0]  req_buf,
   input logic              req_chan,
   input logic [NUM_W-1:0]  last_q,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_hdr_addr,
   input logic              rsp_seg,
   input logic [SIZE_W:0]   rsp_min_len,
   input logic [1:0]        rsp_shadow,
   input logic              rsp_err
);

   localparam int CNT_W = NUM_W + 1;

   assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_idle_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_range_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (CNT_W'(req_buf) >= CNT_W'(NUM_BUF)))
         |=> (rsp_err && (rsp_hdr_addr == '0)));

   assert_in_range_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (CNT_W'(req_buf) < CNT_W'(NUM_BUF))) |=> !rsp_err);

   assert_segment_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_seg == ($past(req_buf) > $past(last_q))));

   assert_shadow_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_shadow[0] == $past(req_chan)));

   assert_even_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_min_len[0] == 1'b0));

endmodule

bind mbuf_addr_map mbam_checker #(
   .NUM_BUF(NUM_BUF), .NUM_W(NUM_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
) u_mbam_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_buf(req_buf),
   .req_chan(req_chan), .last_q(last_q), .rsp_valid(rsp_valid),
   .rsp_hdr_addr(rsp_hdr_addr), .rsp_seg(rsp_seg), .rsp_min_len(rsp_min_len),
   .rsp_shadow(rsp_shadow), .rsp_err(rsp_err)
);

// File: tb/mbuf_addr_map_bench.sv
`timescale 1ns/1ps
module mbuf_addr_map_bench;

   localparam int NUM_BUF = 16;
   localparam int NUM_W   = 6;
   localparam int IDX_W   = 8;
   localparam int ADDR_W  = 16;
   localparam int SIZE_W  = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [2:0]        cfg_kind = '0;
   logic [NUM_W-1:0]  cfg_buf = '0;
   logic [ADDR_W-1:0] cfg_wdata = '0;
   logic              req_valid = 1'b0;
   logic [NUM_W-1:0]  req_buf = '0;
   logic              req_chan = 1'b0;
   logic              rsp_valid;
   logic [ADDR_W-1:0] rsp_hdr_addr;
   logic              rsp_seg;
   logic [SIZE_W:0]   rsp_min_len;
   logic [1:0]        rsp_shadow;
   logic              rsp_err;

   always #10 clk = ~clk;

   mbuf_addr_map u_mbuf_addr_map (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
      .cfg_buf(cfg_buf), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
      .req_buf(req_buf), .req_chan(req_chan), .rsp_valid(rsp_valid),
      .rsp_hdr_addr(rsp_hdr_addr), .rsp_seg(rsp_seg), .rsp_min_len(rsp_min_len),
      .rsp_shadow(rsp_shadow), .rsp_err(rsp_err)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [IDX_W-1:0]  m_idx [NUM_BUF];
   logic [ADDR_W-1:0] m_base;
   logic [NUM_W-1:0]  m_last;
   logic [SIZE_W-1:0] m_s1, m_s2;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] exp_addr(input int b);
      if (b >= NUM_BUF) return '0;
      return ADDR_W'(32'(m_idx[b]) * 10 + 32'(m_base));
   endfunction

   function automatic bit exp_seg(input int b);
      return b > int'(m_last);
   endfunction

   function automatic int exp_len(input int b);
      return exp_seg(b) ? 2 * int'(m_s2) : 2 * int'(m_s1);
   endfunction

   task automatic cfg_write(input int kind, input int b, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_buf = NUM_W'(b); cfg_wdata = ADDR_W'(data);
      @(posedge clk); #1;
      cfg_we = 1'b0;
      case (kind)
         0: if (b < NUM_BUF) m_idx[b] = IDX_W'(data);
         1: m_base = ADDR_W'(data);
         2: m_last = NUM_W'(data);
         3: m_s1 = SIZE_W'(data);
         4: m_s2 = SIZE_W'(data);
         default: ;
      endcase
   endtask

   task automatic issue(input int b, input bit ch);
      @(negedge clk);
      req_valid = 1'b1; req_buf = NUM_W'(b); req_chan = ch;
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_all(input int b, input bit ch);
      bit s;
      s = exp_seg(b);
      check(rsp_valid == 1'b1, "R5 valid", rsp_valid, 1);
      check(rsp_hdr_addr == exp_addr(b), "R1 addr", rsp_hdr_addr, exp_addr(b));
      check(rsp_seg == s, "R2 seg", rsp_seg, s);
      check(int'(rsp_min_len) == exp_len(b), "R3 len", rsp_min_len, exp_len(b));
      check(rsp_shadow == {s, ch}, "R4 shadow", rsp_shadow, {s, ch});
      check(rsp_err == (b >= NUM_BUF), "R8 err", rsp_err, b >= NUM_BUF);
   endtask

   task automatic lookup(input int b, input bit ch);
      issue(b, ch);
      check_all(b, ch);
   endtask

   initial begin
      for (int i = 0; i < NUM_BUF; i++) m_idx[i] = '0;
      m_base = '0; m_last = '0; m_s1 = '0; m_s2 = '0;
      void'($urandom(32'h5eed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R9 reset valid", rsp_valid, 0);
      rst_n = 1'b1;
      // R9: registers zero after reset
      lookup(0, 1'b0);
      lookup(NUM_BUF - 1, 1'b1);
      // R5: no request -> valid drops
      @(negedge clk);
      check(rsp_valid == 1'b0, "R5 idle", rsp_valid, 0);

      // directed configuration
      for (int i = 0; i < NUM_BUF; i++) cfg_write(0, i, (i * 13 + 5) % 256);
      cfg_write(1, 0, 16'h0100);
      cfg_write(2, 0, 7);
      cfg_write(3, 0, 8);
      cfg_write(4, 0, 64);
      // R2 boundary at last and last+1
      lookup(7, 1'b0);
      lookup(8, 1'b1);
      lookup(0, 1'b1);
      lookup(NUM_BUF - 1, 1'b0);
      // R8 boundary: first out-of-range number and the largest number
      lookup(NUM_BUF, 1'b0);
      lookup((1 << NUM_W) - 1, 1'b1);
      // R1 wrap: max index, high base
      cfg_write(0, 3, 255);
      cfg_write(1, 0, 16'hFF00);
      lookup(3, 1'b0);

      // R7: index write to buffer 5 leaves 4 and 6 alone; out-of-range write ignored
      cfg_write(0, 5, 200);
      lookup(4, 1'b0);
      lookup(5, 1'b0);
      lookup(6, 1'b0);
      cfg_write(0, NUM_BUF, 99);
      for (int i = 0; i < NUM_BUF; i++) lookup(i, i[0]);
      // R6: undefined kind codes change nothing
      cfg_write(5, 2, 16'hFFFF);
      cfg_write(7, 2, 16'hFFFF);
      lookup(2, 1'b1);
      lookup(12, 1'b0);

      // R6: write and request in the same cycle -> old base
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = 3'd1; cfg_wdata = 16'h1234;
      req_valid = 1'b1; req_buf = NUM_W'(2); req_chan = 1'b0;
      @(posedge clk); #1;
      cfg_we = 1'b0; req_valid = 1'b0;
      @(negedge clk);
      check(rsp_hdr_addr == exp_addr(2), "R6 same-cycle old value", rsp_hdr_addr, exp_addr(2));
      m_base = 16'h1234;
      lookup(2, 1'b0);  // R6 new value next cycle
      // R6: segment boundary moved, seen by the next lookup
      cfg_write(2, 0, 1);
      lookup(1, 1'b0);
      lookup(2, 1'b1);

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         int r;
         r = int'($urandom % 10);
         if (r < 3) cfg_write(int'($urandom % 5), int'($urandom % (NUM_BUF + 4)), int'($urandom % 65536));
         else if (r == 3) lookup(NUM_BUF + int'($urandom % ((1 << NUM_W) - NUM_BUF)), 1'($urandom));
         else lookup(int'($urandom % NUM_BUF), 1'($urandom));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule